// File: doc/BRIEF.md
# Line 21 Caption Data Inserter

This block puts two caption characters per enabled field onto the caption line of a video frame. The caption line is line 21 in field one and line 284 in field two. A timing generator supplies the line number, the field identity and the clock-accurate horizontal position. During the slot the block drives a one-bit luma-level stream, with a gate that marks when the stream is valid. A later stage shapes this stream into the analog pulse.

The stream has three parts, in this order:
- a run-in of seven cycles,
- a three-bit start code,
- sixteen NRZ data bits.

Each character has seven bits that software writes. The block adds odd parity in the top bit. The bit period is one thirty-second of the line period, which is a non-integer number of clocks. A fractional phase accumulator keeps the long-term rate exact.

Software writes characters through a small register port. A per-field pending flag rises on each write and falls when the block consumes that field's characters. When the slot starts, the characters are taken and the registers are cleared. If software misses a slot, the next one carries null characters.

Top module: `cc_line21_inserter`

## Requirements
- R1: After reset, `cc_out`, `cc_gate`, `pend_f1` and `pend_f2` are low, all character registers are zero, and only field one is enabled.
- R2: A slot starts only in the clock after the block samples `hpos` equal to SLOT_START (300), and only on an enabled field. The line must be `line_num` 21 with `field_two` low, or `line_num` 284 with `field_two` high. A slot on any other line is not started.
- R3: Half-bit periods are numbered 0 to 51 within a slot. Half-bits 0 to 13 alternate high and low, starting high. Each later bit lasts two half-bits. The start code is 0, 0, 1 in transmission order. Next comes the field's first character, least significant bit first, then its second character.
- R4: Bit 7 of each character sent is the odd parity of bits 6:0. Bit 7 of the written value is ignored.
- R5: The half-bit index m clocks into a slot is floor(m*64/LINE_CLKS), with LINE_CLKS = 1716. `cc_gate` stays high for exactly 1395 clocks.
- R6: A write to either character register of a field sets that field's pending flag in the next cycle. The flag is clear in the first cycle of that field's slot, unless a write lands in the same cycle.
- R7: A slot clears its field's characters. The next slot without new writes sends two null characters (0x80 on the line).
- R8: When a field is disabled, its caption line produces no slot, and its characters and pending flag are kept.
- R9: The write address map is: 0 and 1 are the first and second characters of field one, 2 and 3 those of field two, 4 is the control register with bit 0 enabling field one and bit 1 enabling field two. Writes to addresses 5 to 7 have no effect.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one tick per horizontal position |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| line_num | input | 10 | Current line number from the timing generator |
| field_two | input | 1 | High during the second field |
| hpos | input | 11 | Clock count since the start of the line |
| cc_out | output | 1 | Caption level, low outside a slot |
| cc_gate | output | 1 | High while a slot is being sent |
| pend_f1 | output | 1 | Field one characters written and not yet sent |
| pend_f2 | output | 1 | Field two characters written and not yet sent |

## Verification
A wrong phase accumulator value or step shows as a level change moved by one or more clocks. It also shows as a gate length other than 1395 clocks, so it is seen within the slot where it occurs. A wrong half-bit index or wrong segment decode corrupts the run-in, the start code or a data bit, which appears at once at `cc_out`. A capture or clear fault only shows one slot later, when the null characters are sent. For this reason the bench always follows a slot with a second slot that has no new write.

// File: rtl/cc_line21_pkg.sv
package cc_line21_pkg;

  localparam int unsigned RUNIN_HALVES = 14;
  localparam int unsigned START_BITS   = 3;
  localparam int unsigned CHAR_BITS    = 8;
  localparam int unsigned PAYLOAD_BITS = 2 * CHAR_BITS;
  localparam int unsigned TOTAL_HALVES = RUNIN_HALVES + 2 * (START_BITS + PAYLOAD_BITS);
  localparam int unsigned NUM_FIELDS   = 2;

  // start code, bit 0 leaves first: 0, 0, 1
  localparam logic [START_BITS-1:0] START_CODE = 3'b100;

  typedef enum logic [1:0] {
    SEG_RUNIN,
    SEG_START,
    SEG_DATA
  } seg_e;

  function automatic logic [CHAR_BITS-1:0] with_odd_parity(input logic [CHAR_BITS-2:0] d);
    return {~^d, d};
  endfunction

endpackage

// File: rtl/cc_line21_regs.sv
module cc_line21_regs
  import cc_line21_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [ADDR_W-1:0]                     wr_addr,
  input  logic [7:0]                            wr_data,
  input  logic [NUM_FIELDS-1:0]                 capture,
  output logic [2*NUM_FIELDS-1:0][CHAR_BITS-2:0] chars_o,
  output logic [NUM_FIELDS-1:0]                 en_o,
  output logic [NUM_FIELDS-1:0]                 pend_o
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(2 * NUM_FIELDS);

  logic [2*NUM_FIELDS-1:0][CHAR_BITS-2:0] chars_q, chars_d;
  logic [NUM_FIELDS-1:0]                  en_q, en_d;
  logic [NUM_FIELDS-1:0]                  pend_q, pend_d;
  logic                                   upd;
  logic                                   unused_wr;

  assign unused_wr = ^{wr_data[7]};

  always_comb begin
    chars_d = chars_q;
    en_d    = en_q;
    pend_d  = pend_q;
    for (int f = 0; f < int'(NUM_FIELDS); f++) begin
      if (capture[f]) begin
        chars_d[2*f]   = '0;
        chars_d[2*f+1] = '0;
        pend_d[f]      = 1'b0;
      end
    end
    if (wr_en) begin
      if (wr_addr < CTRL_ADDR) begin
        chars_d[wr_addr[1:0]] = wr_data[CHAR_BITS-2:0];
        pend_d[wr_addr[1]]    = 1'b1;
      end else if (wr_addr == CTRL_ADDR) begin
        en_d = wr_data[NUM_FIELDS-1:0];
      end
    end
  end

  assign upd = wr_en | (|capture);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chars_q <= '0;
      en_q    <= NUM_FIELDS'(1);
      pend_q  <= '0;
    end else if (upd) begin
      chars_q <= chars_d;
      en_q    <= en_d;
      pend_q  <= pend_d;
    end
  end

  assign chars_o = chars_q;
  assign en_o    = en_q;
  assign pend_o  = pend_q;

endmodule

// File: rtl/cc_line21_phase.sv
module cc_line21_phase #(
  parameter int unsigned LINE_CLKS = 1716,
  parameter int unsigned STEP      = 64,
  parameter int unsigned HALVES    = 52,
  parameter int unsigned HIDX_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              active_o,
  output logic [HIDX_W-1:0] half_o
);

  localparam int unsigned ACC_W = $clog2(LINE_CLKS + STEP);
  localparam logic [ACC_W:0]    STEP_C   = (ACC_W+1)'(STEP);
  localparam logic [ACC_W:0]    MOD_C    = (ACC_W+1)'(LINE_CLKS);
  localparam logic [HIDX_W-1:0] LAST_IDX = HIDX_W'(HALVES - 1);

  logic [ACC_W-1:0]  acc_q, acc_d;
  logic [HIDX_W-1:0] half_q, half_d;
  logic              active_q, active_d;
  logic [ACC_W:0]    sum;
  logic              wrap;
  logic              upd;

  assign sum  = {1'b0, acc_q} + STEP_C;
  assign wrap = (sum >= MOD_C);

  always_comb begin
    acc_d    = acc_q;
    half_d   = half_q;
    active_d = active_q;
    if (start && !active_q) begin
      acc_d    = '0;
      half_d   = '0;
      active_d = 1'b1;
    end else if (active_q) begin
      if (wrap) begin
        acc_d = ACC_W'(sum - MOD_C);
        if (half_q == LAST_IDX) begin
          half_d   = '0;
          active_d = 1'b0;
        end else begin
          half_d = half_q + 1'b1;
        end
      end else begin
        acc_d = ACC_W'(sum);
      end
    end
  end

  assign upd = start | active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      half_q   <= '0;
      active_q <= 1'b0;
    end else if (upd) begin
      acc_q    <= acc_d;
      half_q   <= half_d;
      active_q <= active_d;
    end
  end

  assign active_o = active_q;
  assign half_o   = half_q;

endmodule

// File: rtl/cc_line21_serial.sv
module cc_line21_serial
  import cc_line21_pkg::*;
#(
  parameter int unsigned HIDX_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [PAYLOAD_BITS-1:0] load_word,
  input  logic                    active,
  input  logic [HIDX_W-1:0]       half_idx,
  output logic                    level_o
);

  localparam int unsigned BIT_W = HIDX_W - 1;
  localparam int unsigned PAY_W = $clog2(PAYLOAD_BITS);

  logic [PAYLOAD_BITS-1:0] word_q, word_d;
  logic [HIDX_W-1:0]       rel;
  logic [BIT_W-1:0]        bit_no;
  logic [BIT_W-1:0]        data_idx;
  seg_e                    seg;
  logic                    lvl;
  logic                    unused_bits;

  always_comb begin
    word_d = word_q;
    if (load) word_d = load_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (load) begin
      word_q <= word_d;
    end
  end

  assign rel      = half_idx - HIDX_W'(RUNIN_HALVES);
  assign bit_no   = rel[HIDX_W-1:1];
  assign data_idx = bit_no - BIT_W'(START_BITS);
  assign unused_bits = ^{rel[0], data_idx[BIT_W-1:PAY_W]};

  always_comb begin
    if (half_idx < HIDX_W'(RUNIN_HALVES)) begin
      seg = SEG_RUNIN;
    end else if (bit_no < BIT_W'(START_BITS)) begin
      seg = SEG_START;
    end else begin
      seg = SEG_DATA;
    end
  end

  always_comb begin
    case (seg)
      SEG_RUNIN: lvl = ~half_idx[0];
      SEG_START: lvl = START_CODE[bit_no[1:0]];
      default:   lvl = word_q[data_idx[PAY_W-1:0]];
    endcase
  end

  assign level_o = active & lvl;

endmodule

// File: rtl/cc_line21_inserter.sv
module cc_line21_inserter
  import cc_line21_pkg::*;
#(
  parameter int unsigned LINE_CLKS     = 1716,
  parameter int unsigned BITS_PER_LINE = 32,
  parameter int unsigned SLOT_START    = 300,
  parameter int unsigned F1_LINE       = 21,
  parameter int unsigned F2_LINE       = 284,
  parameter int unsigned LINE_W        = 10,
  parameter int unsigned HPOS_W        = 11,
  parameter int unsigned ADDR_W        = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field_two,
  input  logic [HPOS_W-1:0] hpos,
  output logic              cc_out,
  output logic              cc_gate,
  output logic              pend_f1,
  output logic              pend_f2
);

  localparam int unsigned HALF_STEP = 2 * BITS_PER_LINE;
  localparam int unsigned HIDX_W    = $clog2(TOTAL_HALVES);

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [2*NUM_FIELDS-1:0][CHAR_BITS-2:0] chars;
  logic [NUM_FIELDS-1:0]                  en;
  logic [NUM_FIELDS-1:0]                  pend;
  logic [NUM_FIELDS-1:0]                  line_hit;
  logic [NUM_FIELDS-1:0]                  capture;
  logic                                   at_slot;
  logic                                   active;
  logic [HIDX_W-1:0]                      half_idx;
  logic [PAYLOAD_BITS-1:0]                load_word;

  assign at_slot = (hpos == HPOS_W'(SLOT_START));

  for (genvar f = 0; f < int'(NUM_FIELDS); f++) begin : g_field
    localparam logic [LINE_W-1:0] CAP_LINE = LINE_W'((f == 0) ? F1_LINE : F2_LINE);
    assign line_hit[f] = (line_num == CAP_LINE) && (field_two == 1'(f));
    assign capture[f]  = at_slot & line_hit[f] & en[f] & ~active;
  end

  always_comb begin
    if (capture[1]) begin
      load_word = {with_odd_parity(chars[3]), with_odd_parity(chars[2])};
    end else begin
      load_word = {with_odd_parity(chars[1]), with_odd_parity(chars[0])};
    end
  end

  cc_line21_regs #(
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .capture (capture),
    .chars_o (chars),
    .en_o    (en),
    .pend_o  (pend)
  );

  cc_line21_phase #(
    .LINE_CLKS (LINE_CLKS),
    .STEP      (HALF_STEP),
    .HALVES    (TOTAL_HALVES),
    .HIDX_W    (HIDX_W)
  ) u_phase (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .start    (|capture),
    .active_o (active),
    .half_o   (half_idx)
  );

  cc_line21_serial #(
    .HIDX_W (HIDX_W)
  ) u_serial (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .load      (|capture),
    .load_word (load_word),
    .active    (active),
    .half_idx  (half_idx),
    .level_o   (cc_out)
  );

  assign cc_gate = active;
  assign pend_f1 = pend[0];
  assign pend_f2 = pend[1];

endmodule

// File: rtl/cc_line21_checker.sv
module cc_line21_checker #(
  parameter int unsigned LINE_CLKS     = 1716,
  parameter int unsigned BITS_PER_LINE = 32,
  parameter int unsigned SLOT_START    = 300,
  parameter int unsigned F1_LINE       = 21,
  parameter int unsigned F2_LINE       = 284,
  parameter int unsigned LINE_W        = 10,
  parameter int unsigned HPOS_W        = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [LINE_W-1:0] line_num,
  input logic              field_two,
  input logic [HPOS_W-1:0] hpos,
  input logic              cc_out,
  input logic              cc_gate,
  input logic              pend_f1,
  input logic              pend_f2
);

  localparam int unsigned STEP      = 2 * BITS_PER_LINE;
  localparam int unsigned HALVES    = cc_line21_pkg::TOTAL_HALVES;
  localparam int unsigned GATE_CLKS = (HALVES * LINE_CLKS + STEP - 1) / STEP;

  logic [15:0] gate_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_cnt_q <= '0;
    end else if (cc_gate) begin
      gate_cnt_q <= gate_cnt_q + 16'd1;
    end else begin
      gate_cnt_q <= '0;
    end
  end

  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cc_gate |-> !cc_out);

  a_r2_slot_place: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cc_gate) |-> ($past(hpos) == HPOS_W'(SLOT_START)) &&
      ((($past(line_num) == LINE_W'(F1_LINE)) && !$past(field_two)) ||
       (($past(line_num) == LINE_W'(F2_LINE)) &&  $past(field_two))));

  a_r3_runin_high_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cc_gate) |-> cc_out);

  a_r5_gate_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cc_gate) |-> (gate_cnt_q == 16'(GATE_CLKS)));

  a_r6_pend1_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cc_gate) && !$past(field_two) && !$past(wr_en)) |-> !pend_f1);

  a_r6_pend2_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cc_gate) && $past(field_two) && !$past(wr_en)) |-> !pend_f2);

endmodule

bind cc_line21_inserter cc_line21_checker #(
  .LINE_CLKS     (LINE_CLKS),
  .BITS_PER_LINE (BITS_PER_LINE),
  .SLOT_START    (SLOT_START),
  .F1_LINE       (F1_LINE),
  .F2_LINE       (F2_LINE),
  .LINE_W        (LINE_W),
  .HPOS_W        (HPOS_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .line_num  (line_num),
  .field_two (field_two),
  .hpos      (hpos),
  .cc_out    (cc_out),
  .cc_gate   (cc_gate),
  .pend_f1   (pend_f1),
  .pend_f2   (pend_f2)
);

// File: tb/cc_line21_inserter_bench.sv
module cc_line21_inserter_bench;

  localparam int LINE  = 1716;
  localparam int START = 300;
  localparam int STEPH = 64;
  localparam int HALF_TOTAL = 52;

  logic       clk, rst_n, wr_en, field_two;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [9:0] line_num;
  logic [10:0] hpos;
  logic       cc_out, cc_gate, pend_f1, pend_f2;

  int checks = 0;
  int errors = 0;
  logic [1:0] pend_m;

  cc_line21_inserter u_cc_line21_inserter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .line_num(line_num), .field_two(field_two), .hpos(hpos),
    .cc_out(cc_out), .cc_gate(cc_gate), .pend_f1(pend_f1), .pend_f2(pend_f2)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  // vector: {write, ctrl[1:0], field, b0, b1, go, exp0, exp1}
  localparam int NV = 7;
  localparam logic [36:0] VEC [0:NV-1] = '{
    {1'b0, 2'b01, 1'b0, 8'h00, 8'h00, 1'b1, 8'h80, 8'h80},
    {1'b1, 2'b01, 1'b0, 8'h41, 8'h42, 1'b1, 8'hC1, 8'hC2},
    {1'b0, 2'b01, 1'b0, 8'h00, 8'h00, 1'b1, 8'h80, 8'h80},
    {1'b1, 2'b01, 1'b1, 8'h7F, 8'h83, 1'b0, 8'h00, 8'h00},
    {1'b0, 2'b11, 1'b1, 8'h00, 8'h00, 1'b1, 8'h7F, 8'h83},
    {1'b1, 2'b10, 1'b0, 8'h00, 8'h01, 1'b0, 8'h00, 8'h00},
    {1'b0, 2'b11, 1'b0, 8'h00, 8'h00, 1'b1, 8'h80, 8'h01}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic exp_level(input int h, input logic [7:0] e0, input logic [7:0] e1);
    int b;
    if (h < 14) return (h % 2) == 0;
    b = (h - 14) / 2;
    if (b < 3) return b == 2;
    if (b < 11) return e0[b-3];
    return e1[b-11];
  endfunction

  task automatic check_pend(input string req);
    check({pend_f2, pend_f1} == pend_m, req, "pending flags",
          int'({pend_f2, pend_f1}), int'(pend_m));
  endtask

  task automatic run_line(input logic f, input logic [9:0] ln, input bit go,
                          input logic [7:0] e0, input logic [7:0] e1, input string req);
    int gate_bad = 0;
    int data_bad = 0;
    int first_c = -1;
    int act_v = 0;
    int exp_v = 0;
    for (int c = 0; c < LINE; c++) begin
      int m;
      bit eg;
      logic el;
      @(negedge clk);
      line_num = ln; field_two = f; hpos = 11'(c);
      @(posedge clk);
      #1;
      m  = c - START;
      eg = go && (m >= 0) && (m * STEPH < HALF_TOTAL * LINE);
      el = eg ? exp_level((m * STEPH) / LINE, e0, e1) : 1'b0;
      if (cc_gate !== eg) begin
        gate_bad++;
        if (first_c < 0) begin first_c = c; act_v = int'(cc_gate); exp_v = int'(eg); end
      end
      if (cc_out !== el) begin
        data_bad++;
        if (first_c < 0) begin first_c = c; act_v = int'(cc_out); exp_v = int'(el); end
      end
      if (go && m == 0) begin
        logic pf;
        pf = f ? pend_f2 : pend_f1;
        check(pf == 1'b0, "R6", "pending at slot start", int'(pf), 0);
      end
    end
    check(gate_bad == 0, req, $sformatf("gate window (first bad hpos %0d)", first_c), act_v, exp_v);
    check(data_bad == 0, "R3", $sformatf("line level (first bad hpos %0d)", first_c), act_v, exp_v);
    @(negedge clk);
    line_num = 10'd0; hpos = 11'd0;
    if (go) pend_m[f] = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    pend_m = 2'b00;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    line_num = '0; field_two = 1'b0; hpos = '0; pend_m = 2'b00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(cc_gate == 1'b0, "R1", "gate after reset", int'(cc_gate), 0);
    check(cc_out == 1'b0, "R1", "level after reset", int'(cc_out), 0);
    check_pend("R1");

    // table walk: R3 R4 R5 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic [36:0] v;
      logic fl;
      v  = VEC[i];
      fl = v[33];
      write_reg(3'd4, {6'd0, v[35:34]});
      if (v[36]) begin
        write_reg({1'b0, fl, 1'b0}, v[32:25]);
        write_reg({1'b0, fl, 1'b1}, v[24:17]);
        pend_m[fl] = 1'b1;
      end
      check_pend("R6");
      run_line(fl, fl ? 10'd284 : 10'd21, v[16], v[15:8], v[7:0], v[16] ? "R5" : "R8");
      check_pend(v[16] ? "R7" : "R8");
    end

    // R2 wrong lines or wrong field never start a slot
    write_reg(3'd0, 8'h55);
    write_reg(3'd1, 8'h2A);
    pend_m[0] = 1'b1;
    check_pend("R6");
    run_line(1'b0, 10'd22, 1'b0, 8'h00, 8'h00, "R2");
    run_line(1'b1, 10'd21, 1'b0, 8'h00, 8'h00, "R2");
    run_line(1'b0, 10'd284, 1'b0, 8'h00, 8'h00, "R2");
    check_pend("R2");
    run_line(1'b0, 10'd21, 1'b1, 8'hD5, 8'h2A, "R2");
    check_pend("R7");

    // R9 unmapped addresses do nothing
    write_reg(3'd5, 8'h00);
    write_reg(3'd6, 8'h7F);
    write_reg(3'd7, 8'h7F);
    check_pend("R9");
    run_line(1'b0, 10'd21, 1'b1, 8'h80, 8'h80, "R9");

    // R1 reset mid-run restores defaults
    write_reg(3'd2, 8'h11);
    pend_m[1] = 1'b1;
    check_pend("R6");
    do_reset();
    check_pend("R1");
    run_line(1'b1, 10'd284, 1'b0, 8'h00, 8'h00, "R1");
    check(cc_out == 1'b0, "R1", "level idle", int'(cc_out), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule